// File: doc/BRIEF.md
# Serial Pixel Lane Aligner and Colour Unmapper

This block sits behind the samplers of a low-voltage differential pixel link. Every fast clock it receives one sampled bit from the link's clock lane and one from each of four data lanes. The fast clock runs at seven times the pixel rate, so each lane carries seven bits per pixel. The block finds the pixel boundary by looking for the clock lane's fixed high/low shape in any of the seven possible rotations. Once it has seen that shape at the same rotation for several frames in a row, it declares lock.

While it is locked, the block takes each aligned set of lane words and undoes the slot map selected by a mode input. There are three maps: one 18-bit map that uses three lanes, and two 24-bit maps that use four lanes and differ in which colour bits travel on the fourth lane. The block emits one pixel per frame: 8-bit red, green and blue, horizontal sync, vertical sync and data enable, together with a one-cycle valid strobe. If the spare control slot is non-zero in a 24-bit mode, a sticky error flag is raised. Sampling, lane deskew and clock recovery are outside this block.

Top module: `lvdsRxAligner`

## Requirements
- R1: While reset is asserted, and after it is released, `locked`, `pixValid` and `ctl3Err` are 0 and all pixel outputs are 0.
- R2: Each lane is received as 7-slot frames, and slot 0 is the first bit of a frame on the wire. The clock lane carries the pattern 1,1,0,0,0,1,1 over slots 0 to 6, and a frame boundary is recognised in any of the 7 bit rotations.
- R3: `locked` rises after the 4th consecutive frame whose clock pattern sits at the same rotation. The first valid pixel is the one decoded from that 4th frame, and no pixel is produced from the 3 frames before it.
- R4: `pixValid` is a one-cycle pulse, high only while `locked` is 1, and successive pulses are exactly 7 cycles apart while lock holds.
- R5: A single frame with a wrong clock pattern keeps lock, and its data is still output as a pixel. Two consecutive wrong frames drop `locked`, and the second of them produces no pixel.
- R6: Mode 0 (18-bit) decodes only lanes 0 to 2. Lane 0 slots 0..6 carry G0,R5,R4,R3,R2,R1,R0. Lane 1 carries B1,B0,G5,G4,G3,G2,G1. Lane 2 carries C2,C1,C0,B5,B4,B3,B2. Each output colour is {c[5:0], c[5:4]}, so lane 3 has no effect. Mode 3 behaves as mode 0.
- R7: Mode 1 (24-bit) uses the lane 0 to 2 layout of R6 but with colour bits 7..2 in place of 5..0. Lane 3 slots 0..6 carry C3,B1,B0,G1,G0,R1,R0.
- R8: Mode 2 (24-bit) uses the lane 0 to 2 layout of R6 for colour bits 5..0. Lane 3 slots 0..6 carry C3,B7,B6,G7,G6,R7,R6.
- R9: Control slots C0, C1 and C2 are output as `pixHsync`, `pixVsync` and `pixDe`.
- R10: In modes 1 and 2, a decoded pixel with C3 = 1 sets `ctl3Err`. The flag stays set until reset. In modes 0 and 3, C3 is ignored.
- R11: After lock is lost, the block locks again at a new rotation after 4 consecutive matching frames at that rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, 7 per pixel |
| rstN | input | 1 | Active-low synchronous reset |
| clkLaneBit | input | 1 | Sampled bit of the link's clock lane |
| dataLaneBits | input | 4 | Sampled bits of data lanes 3..0 |
| mapMode | input | 2 | 0: 18-bit, 1: 24-bit high-in-base, 2: 24-bit low-in-base, 3: as 0 |
| pixR | output | 8 | Decoded red |
| pixG | output | 8 | Decoded green |
| pixB | output | 8 | Decoded blue |
| pixHsync | output | 1 | Decoded horizontal sync |
| pixVsync | output | 1 | Decoded vertical sync |
| pixDe | output | 1 | Decoded data enable |
| pixValid | output | 1 | One-cycle strobe per decoded pixel |
| locked | output | 1 | Frame alignment is held |
| ctl3Err | output | 1 | Sticky spare-slot error |

## Verification
The bench uses the default configuration: 7 slots, 4 lanes, 8-bit colour, a lock threshold of 4 frames and an unlock threshold of 2 misses. With these values a short stream covers every 6-bit code in the 18-bit mode and every 8-bit value per channel in each 24-bit mode. It also reaches the exact frame at which lock rises, a single-miss and a double-miss recovery, and realignment after a 3-bit slip, all within a few thousand cycles. Expected pixels come from a forward lane encoder in the bench, and they are matched in order against every valid strobe.

// File: rtl/lvdsRxPkg.sv
package lvdsRxPkg;
  localparam int SLOT_CNT   = 7;
  localparam int LANE_CNT   = 4;
  localparam int COLOR_BITS = 8;
  localparam logic [SLOT_CNT-1:0] CLK_SHAPE = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18      = 2'd0,
    MAP_24_HIGH = 2'd1,
    MAP_24_LOW  = 2'd2,
    MAP_RSVD    = 2'd3
  } mapMode_e;

  // strobes from the alignment control to the deframing datapath
  typedef struct packed {
    logic capture;
    logic wide24;
  } ctlStrobe_t;

  typedef struct packed {
    logic [COLOR_BITS-1:0] r;
    logic [COLOR_BITS-1:0] g;
    logic [COLOR_BITS-1:0] b;
    logic hsync;
    logic vsync;
    logic de;
    logic ctl3;
  } pixel_t;
endpackage

// File: rtl/lvdsSlotUnmap.sv
module lvdsSlotUnmap
  import lvdsRxPkg::*;
#(
  parameter int SLOTS   = SLOT_CNT,
  parameter int LANES   = LANE_CNT,
  parameter int COLOR_W = COLOR_BITS
) (
  input  logic [LANES-1:0][SLOTS-1:0] words,
  input  mapMode_e                    mode,
  output pixel_t                      pix
);
  localparam int BASE_W = SLOTS - 1;
  localparam int EXT_W  = COLOR_W - BASE_W;
  localparam int NCOL   = 3;

  // word bit 6 is slot 0, bit 0 is slot 6
  logic [BASE_W-1:0] base [NCOL];
  logic [EXT_W-1:0]  ext  [NCOL];
  logic [COLOR_W-1:0] full [NCOL];

  assign base[0] = words[0][5:0];
  assign base[1] = {words[1][4:0], words[0][6]};
  assign base[2] = {words[2][3:0], words[1][6:5]};
  assign ext[0]  = words[3][1:0];
  assign ext[1]  = words[3][3:2];
  assign ext[2]  = words[3][5:4];

  for (genvar c = 0; c < NCOL; c++) begin : gColour
    assign full[c] = (mode == MAP_24_HIGH) ? {base[c], ext[c]} :
                     (mode == MAP_24_LOW)  ? {ext[c], base[c]} :
                                             {base[c], base[c][BASE_W-1 -: EXT_W]};
  end

  always_comb begin
    pix.r     = full[0];
    pix.g     = full[1];
    pix.b     = full[2];
    pix.hsync = words[2][4];
    pix.vsync = words[2][5];
    pix.de    = words[2][6];
    pix.ctl3  = words[3][6];
  end
endmodule

// File: rtl/lvdsAlignCtrl.sv
module lvdsAlignCtrl
  import lvdsRxPkg::*;
#(
  parameter int SLOTS         = SLOT_CNT,
  parameter int LOCK_HITS     = 4,
  parameter int UNLOCK_MISSES = 2,
  parameter logic [SLOTS-1:0] PATTERN = CLK_SHAPE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] clkWord,
  input  mapMode_e         mode,
  output ctlStrobe_t       strobe,
  output logic             locked
);
  localparam int PH_W   = $clog2(SLOTS);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(UNLOCK_MISSES + 1);

  logic [PH_W-1:0]   phase, cand, candNext;
  logic [HIT_W-1:0]  hitCnt, hitNext;
  logic [MISS_W-1:0] missCnt, missNext;
  logic              lockNext, match, atCand;

  always_comb begin
    match    = (clkWord == PATTERN);
    atCand   = (phase == cand);
    candNext = cand;
    hitNext  = hitCnt;
    missNext = missCnt;
    lockNext = locked;
    if (!locked) begin
      if (match) begin
        if (atCand && hitCnt != '0) hitNext = hitCnt + 1'b1;
        else begin
          candNext = phase;
          hitNext  = HIT_W'(1);
        end
      end else if (atCand) begin
        hitNext = '0;
      end
      if (hitNext == HIT_W'(LOCK_HITS)) begin
        lockNext = 1'b1;
        missNext = '0;
      end
    end else if (atCand) begin
      if (match) missNext = '0;
      else       missNext = missCnt + 1'b1;
      if (missNext == MISS_W'(UNLOCK_MISSES)) begin
        lockNext = 1'b0;
        hitNext  = '0;
      end
    end
    strobe.capture = lockNext && (phase == candNext);
    strobe.wide24  = (mode == MAP_24_HIGH) || (mode == MAP_24_LOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      cand    <= '0;
      hitCnt  <= '0;
      missCnt <= '0;
      locked  <= 1'b0;
    end else begin
      phase   <= (phase == PH_W'(SLOTS - 1)) ? '0 : phase + 1'b1;
      cand    <= candNext;
      hitCnt  <= hitNext;
      missCnt <= missNext;
      locked  <= lockNext;
    end
  end

  // spacing monitor for the capture strobe
  logic [PH_W:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                              gapCnt <= '0;
    else if (strobe.capture)                gapCnt <= '0;
    else if (gapCnt != (PH_W+1)'(SLOTS))    gapCnt <= gapCnt + 1'b1;
  end

  p_strobe_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && locked) |-> (gapCnt == (PH_W+1)'(SLOTS - 1)));

  p_lock_on_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(match));

  p_unlock_on_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(!match && atCand));
endmodule

// File: rtl/lvdsDeframePath.sv
module lvdsDeframePath
  import lvdsRxPkg::*;
#(
  parameter int SLOTS   = SLOT_CNT,
  parameter int LANES   = LANE_CNT,
  parameter int COLOR_W = COLOR_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkBit,
  input  logic [LANES-1:0] dataBits,
  input  mapMode_e         mode,
  input  ctlStrobe_t       strobe,
  output logic [SLOTS-1:0] clkWord,
  output pixel_t           pixQ,
  output logic             pixValid,
  output logic             ctlErr
);
  logic [LANES-1:0][SLOTS-1:0] laneSr;
  pixel_t decoded;

  always_ff @(posedge clk) begin
    if (!rstN) clkWord <= '0;
    else       clkWord <= {clkWord[SLOTS-2:0], clkBit};
  end

  for (genvar k = 0; k < LANES; k++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) laneSr[k] <= '0;
      else       laneSr[k] <= {laneSr[k][SLOTS-2:0], dataBits[k]};
    end
  end

  lvdsSlotUnmap #(.SLOTS(SLOTS), .LANES(LANES), .COLOR_W(COLOR_W)) uUnmap (
    .words(laneSr),
    .mode (mode),
    .pix  (decoded)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixQ     <= '0;
      pixValid <= 1'b0;
      ctlErr   <= 1'b0;
    end else begin
      pixValid <= strobe.capture;
      if (strobe.capture) pixQ <= decoded;
      if (strobe.capture && strobe.wide24 && decoded.ctl3) ctlErr <= 1'b1;
    end
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctlErr |=> ctlErr);

  p_err_only_wide_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlErr) |-> $past(strobe.wide24 && strobe.capture));

  p_fill_replica_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(mode == MAP_18)) |->
      (pixQ.r[1:0] == pixQ.r[7:6] && pixQ.g[1:0] == pixQ.g[7:6] && pixQ.b[1:0] == pixQ.b[7:6]));
endmodule

// File: rtl/lvdsRxAligner.sv
module lvdsRxAligner
  import lvdsRxPkg::*;
#(
  parameter int SLOTS         = SLOT_CNT,
  parameter int LANES         = LANE_CNT,
  parameter int COLOR_W       = COLOR_BITS,
  parameter int LOCK_HITS     = 4,
  parameter int UNLOCK_MISSES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkLaneBit,
  input  logic [LANES-1:0]   dataLaneBits,
  input  logic [1:0]         mapMode,
  output logic [COLOR_W-1:0] pixR,
  output logic [COLOR_W-1:0] pixG,
  output logic [COLOR_W-1:0] pixB,
  output logic               pixHsync,
  output logic               pixVsync,
  output logic               pixDe,
  output logic               pixValid,
  output logic               locked,
  output logic               ctl3Err
);
  mapMode_e         modeE;
  ctlStrobe_t       strobe;
  logic [SLOTS-1:0] clkWord;
  pixel_t           pixQ;

  assign modeE = mapMode_e'(mapMode);

  lvdsAlignCtrl #(
    .SLOTS(SLOTS), .LOCK_HITS(LOCK_HITS), .UNLOCK_MISSES(UNLOCK_MISSES), .PATTERN(CLK_SHAPE)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .clkWord(clkWord),
    .mode   (modeE),
    .strobe (strobe),
    .locked (locked)
  );

  lvdsDeframePath #(.SLOTS(SLOTS), .LANES(LANES), .COLOR_W(COLOR_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .clkBit  (clkLaneBit),
    .dataBits(dataLaneBits),
    .mode    (modeE),
    .strobe  (strobe),
    .clkWord (clkWord),
    .pixQ    (pixQ),
    .pixValid(pixValid),
    .ctlErr  (ctl3Err)
  );

  assign pixR     = pixQ.r;
  assign pixG     = pixQ.g;
  assign pixB     = pixQ.b;
  assign pixHsync = pixQ.hsync;
  assign pixVsync = pixQ.vsync;
  assign pixDe    = pixQ.de;

  p_valid_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> locked);
endmodule

// File: tb/lvdsRxAligner_test.sv
module lvdsRxAligner_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       clkLaneBit = 1'b0;
  logic [3:0] dataLaneBits = '0;
  logic [1:0] mapMode = '0;
  logic [7:0] pixR, pixG, pixB;
  logic       pixHsync, pixVsync, pixDe, pixValid, locked, ctl3Err;

  lvdsRxAligner uut (
    .clk(clk), .rstN(rstN), .clkLaneBit(clkLaneBit), .dataLaneBits(dataLaneBits),
    .mapMode(mapMode), .pixR(pixR), .pixG(pixG), .pixB(pixB), .pixHsync(pixHsync),
    .pixVsync(pixVsync), .pixDe(pixDe), .pixValid(pixValid), .locked(locked),
    .ctl3Err(ctl3Err)
  );

  localparam logic [6:0] SHAPE = 7'b1100011;

  typedef struct packed {
    logic [7:0] r, g, b;
    logic h, v, d;
  } expPix_t;

  expPix_t expQ[$];
  int      checks = 0;
  int      fails  = 0;
  string   curReq = "R6";
  logic    prevLocked, prevErr;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // forward encoder: word bit 6 goes out in slot 0
  function automatic logic [3:0][6:0] encodeFrame(input logic [1:0] m,
      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
      input logic h, input logic v, input logic d, input logic c3);
    logic [5:0] br, bg, bb;
    logic [1:0] er, eg, eb;
    logic [3:0][6:0] w;
    if (m == 2'd1) begin
      br = r[7:2]; bg = g[7:2]; bb = b[7:2];
      er = r[1:0]; eg = g[1:0]; eb = b[1:0];
    end else begin
      br = r[5:0]; bg = g[5:0]; bb = b[5:0];
      er = r[7:6]; eg = g[7:6]; eb = b[7:6];
    end
    w[0] = {bg[0], br};
    w[1] = {bb[1:0], bg[5:1]};
    w[2] = {d, v, h, bb[5:2]};
    w[3] = {c3, eb, eg, er};
    return w;
  endfunction

  function automatic logic [7:0] expColour(input logic [1:0] m, input logic [7:0] c);
    if (m == 2'd1 || m == 2'd2) return c;
    return {c[5:0], c[5:4]};
  endfunction

  task automatic sendFrame(input logic [1:0] m, input logic [7:0] r, input logic [7:0] g,
                           input logic [7:0] b, input logic h, input logic v, input logic d,
                           input logic c3, input bit goodClk, input bit expectOut);
    logic [3:0][6:0] w;
    expPix_t e;
    w = encodeFrame(m, r, g, b, h, v, d, c3);
    if (expectOut) begin
      e = '{r: expColour(m, r), g: expColour(m, g), b: expColour(m, b), h: h, v: v, d: d};
      expQ.push_back(e);
    end
    for (int s = 0; s < 7; s++) begin
      clkLaneBit = goodClk ? SHAPE[6-s] : 1'b0;
      for (int k = 0; k < 4; k++) dataLaneBits[k] = w[k][6-s];
      @(negedge clk);
      if (s == 0) begin
        prevLocked = locked;
        prevErr    = ctl3Err;
      end
    end
  endtask

  task automatic sendIdle(input int n);
    for (int i = 0; i < n; i++) begin
      clkLaneBit   = 1'b0;
      dataLaneBits = '0;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    clkLaneBit = 1'b0;
    dataLaneBits = '0;
    repeat (3) @(negedge clk);
    check(locked == 1'b0, "R1", "locked in reset", locked, 0);
    check(pixValid == 1'b0, "R1", "valid in reset", pixValid, 0);
    check(ctl3Err == 1'b0, "R1", "error in reset", ctl3Err, 0);
    check({pixR, pixG, pixB, pixHsync, pixVsync, pixDe} == '0, "R1", "pixel in reset",
          int'({pixR, pixG, pixB}), 0);
    rstN = 1'b1;
  endtask

  task automatic flushCheck(input string req);
    sendIdle(2);
    check(expQ.size() == 0, req, "pixels missing", expQ.size(), 0);
    expQ.delete();
  endtask

  // monitor: ordered pixel comparison and strobe spacing (R4)
  int gap = 0;
  bit seen = 1'b0;
  always @(negedge clk) begin
    if (!rstN) begin
      seen = 1'b0;
      gap  = 0;
    end else begin
      gap++;
      if (pixValid) begin
        expPix_t e;
        check(locked == 1'b1, "R4", "valid while unlocked", locked, 1);
        if (seen) check(gap == 7, "R4", "strobe spacing", gap, 7);
        gap  = 0;
        seen = 1'b1;
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected pixel", 1, 0);
        end else begin
          e = expQ.pop_front();
          checks++;
          if ({pixR, pixG, pixB, pixHsync, pixVsync, pixDe} != e) begin
            fails++;
            $display("FAIL %s pixel: actual r%02h g%02h b%02h h%0d v%0d d%0d expected r%02h g%02h b%02h h%0d v%0d d%0d",
                     curReq, pixR, pixG, pixB, pixHsync, pixVsync, pixDe,
                     e.r, e.g, e.b, e.h, e.v, e.d);
          end
        end
      end
      if (!locked) seen = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state, then mode 0 sweep over all 6-bit codes (R2, R3, R6, R9, R10)
    mapMode = 2'd0;
    doReset();
    curReq = "R6/R9";
    for (int i = 0; i < 68; i++) begin
      sendFrame(2'd0, 8'(i - 3), 8'(i * 37 + 5), 8'(255 - i * 3),
                i[0], i[1], i[2], 1'b1, 1'b1, i >= 3);
      if (i == 3) check(prevLocked == 1'b0, "R3", "locked after 3 frames", prevLocked, 0);
      if (i == 4) check(prevLocked == 1'b1, "R3", "locked after 4 frames", prevLocked, 1);
    end
    flushCheck("R3");
    check(ctl3Err == 1'b0, "R10", "C3 ignored in mode 0", ctl3Err, 0);

    // R7: 24-bit, high bits in base lanes, all 256 values per channel
    mapMode = 2'd1;
    doReset();
    curReq = "R7";
    for (int i = 0; i < 259; i++) begin
      sendFrame(2'd1, 8'(i - 3), 8'(i * 29 + 3), 8'(~(i * 5)),
                i[2], i[0], i[1], 1'b0, 1'b1, i >= 3);
    end
    flushCheck("R7");
    check(ctl3Err == 1'b0, "R10", "no error with C3 clear", ctl3Err, 0);

    // R8: 24-bit, low bits in base lanes
    mapMode = 2'd2;
    doReset();
    curReq = "R8";
    for (int i = 0; i < 259; i++) begin
      sendFrame(2'd2, 8'(i * 11 + 7), 8'(i - 3), 8'(i * 93),
                i[1], i[2], i[0], 1'b0, 1'b1, i >= 3);
    end
    flushCheck("R8");

    // R10: sticky spare-slot error
    mapMode = 2'd1;
    doReset();
    curReq = "R10";
    for (int i = 0; i < 10; i++) begin
      sendFrame(2'd1, 8'(i * 17), 8'(i * 3), 8'(200 - i), 1'b0, 1'b1, 1'b1,
                i == 6, 1'b1, i >= 3);
      if (i == 6) check(prevErr == 1'b0, "R10", "error before C3", prevErr, 0);
      if (i == 7) check(prevErr == 1'b1, "R10", "error after C3", prevErr, 1);
      if (i == 9) check(prevErr == 1'b1, "R10", "error sticky", prevErr, 1);
    end
    flushCheck("R10");
    doReset();
    check(ctl3Err == 1'b0, "R10", "error cleared by reset", ctl3Err, 0);

    // R5 / R11 in mode 3 (decoded as mode 0)
    mapMode = 2'd3;
    curReq = "R5";
    for (int i = 0; i < 11; i++) begin
      bit bad;
      bad = (i == 6) || (i == 9) || (i == 10);
      sendFrame(2'd3, 8'(i * 9), 8'(i * 21), 8'(i + 40), i[0], 1'b0, 1'b1, 1'b1,
                !bad, (i >= 3) && (i != 10));
      if (i == 7) check(prevLocked == 1'b1, "R5", "lock kept after one miss", prevLocked, 1);
    end
    sendIdle(3);
    check(locked == 1'b0, "R5", "lock dropped after two misses", locked, 0);
    curReq = "R11";
    for (int i = 0; i < 8; i++) begin
      sendFrame(2'd3, 8'(i * 13), 8'(i * 7), 8'(i * 5), 1'b1, i[0], 1'b0, 1'b0,
                1'b1, i >= 3);
      if (i == 3) check(prevLocked == 1'b0, "R11", "relock not early", prevLocked, 0);
      if (i == 4) check(prevLocked == 1'b1, "R11", "relock at new rotation", prevLocked, 1);
    end
    flushCheck("R11");
    check(ctl3Err == 1'b0, "R10", "C3 ignored in mode 3", ctl3Err, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule